// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Port

This block watches an eight-bit input port and turns chosen signal transitions on each pin into a processor interrupt request. Every pin passes through a two-flop synchronizer. It has a polarity bit that picks a rising or a falling trigger, a sticky event flag and a per-pin enable. A single global enable masks every source at once. The request line stays high for as long as any enabled flag is pending while the global enable is set.

Software reaches five small registers through a single-cycle write strobe and a combinational read port. It can clear flags with write-one-to-clear and raise a flag itself as a software interrupt. It can also program the enable and polarity masks and turn the global enable on or off. Flags keep their state until software clears them. An edge that arrives while a handler is running therefore raises the request again once the handler has cleared its own bit.

Top module: `gpio_edge_irq`

## Requirements
- R1: With polarity bit 0 for a pin, a low-to-high transition on that pin sets its flag bit.
- R2: With polarity bit 1 for a pin, a high-to-low transition on that pin sets its flag bit. A transition in the other direction sets nothing.
- R3: A pin that holds a constant level never sets its flag. This includes a pin that is already high when reset is released.
- R4: `irq_o` is a register that loads (global enable AND OR over pins of flag AND enable). It follows its inputs with one cycle of latency.
- R5: While the global enable is 0, `irq_o` stays low. Flags still set on qualifying edges during that time.
- R6: Writing address 0 clears each flag bit whose write-data bit is 1. Flag bits written with 0 are left unchanged.
- R7: If a clear at address 0 and a new qualifying edge hit the same flag bit in the same cycle, the flag stays set.
- R8: Writing the polarity register (address 3) never sets a flag by itself.
- R9: Writing address 1 sets each flag bit whose write-data bit is 1, so software can raise an interrupt.
- R10: A flag that sets while another enabled flag is pending, or after the pending flags have been cleared, keeps or re-raises `irq_o`.
- R11: After reset, the flags, enables, polarity bits, global enable and `irq_o` are all 0.
- R12: The register map is as follows. Addresses 0 and 1 read the flags. Address 2 reads and writes the enable mask. Address 3 reads and writes the polarity mask (1 = falling). Bit 0 of address 4 is the global enable. Addresses 5 to 7 read 0 and ignore writes.
- R13: A pin transition driven before clock edge k shows up in the flag register after edge k+2, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Asynchronous pin inputs |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench targets four corner cases.

- A pin that is high out of reset: a detector without a warm-up phase would report a false rising edge.
- A polarity rewrite on a pin held at a steady level: a level-compare design would fire at that moment.
- A write-one-to-clear that lands on the very cycle a new edge arrives: a design with the wrong priority would lose that edge.
- A handler that clears only its own bit while a second event is pending: a design that drops the request on any clear would miss the second one.

A behavioural model tracks the pin history, the registers and the request cycle by cycle. It catches off-by-one latency in the synchronizer or in the request register.

// File: rtl/gpio_edge_irq_pkg.sv
package gpio_edge_irq_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_FLAG_CLR = 3'd0,
    REG_FLAG_SET = 3'd1,
    REG_ENABLE   = 3'd2,
    REG_POLARITY = 3'd3,
    REG_GLOBAL   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/gpio_edge_irq_sync.sv
module gpio_edge_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_irq_detect.sv
module gpio_edge_irq_detect #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic [WIDTH-1:0] evt_o
);
  // detection waits until the history register holds real pin data
  localparam int unsigned ARM_CYCLES = STAGES + 1;
  localparam int unsigned CW = $clog2(ARM_CYCLES + 1);

  logic [WIDTH-1:0] prev_q;
  logic [CW-1:0]    arm_q;
  logic             armed;
  logic [WIDTH-1:0] rise, fall;

  assign armed = (arm_q == CW'(ARM_CYCLES));
  assign rise  = sync_i & ~prev_q;
  assign fall  = ~sync_i & prev_q;
  assign evt_o = {WIDTH{armed}} & ((rise & ~pol_i) | (fall & pol_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      arm_q  <= '0;
    end else begin
      prev_q <= sync_i;
      if (!armed) arm_q <= arm_q + 1'b1;
    end
  end

  p_level_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i == prev_q) |-> (evt_o == '0));
endmodule

// File: rtl/gpio_edge_irq_flags.sv
module gpio_edge_irq_flags #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] evt_i,
  input  logic [WIDTH-1:0] clr_i,
  input  logic [WIDTH-1:0] set_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] flag_q;

  // new events override a concurrent clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i | evt_i;
  end

  assign flag_o = flag_q;

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~flag_q & $past(flag_q) & ~$past(clr_i)) == '0));

  p_edge_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & clr_i) != '0) |=> ((flag_q & $past(evt_i & clr_i)) == $past(evt_i & clr_i)));

  p_sw_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_irq_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  pin_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] pin_sync, evt, flags, clr, set;
  logic [WIDTH-1:0] en_q, pol_q;
  logic             gie_q, irq_q;

  gpio_edge_irq_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(pin_i), .sync_o(pin_sync)
  );

  gpio_edge_irq_detect #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_detect (
    .clk_i, .rst_ni, .sync_i(pin_sync), .pol_i(pol_q), .evt_o(evt)
  );

  assign clr = (we_i && addr_i == REG_FLAG_CLR) ? wdata_i : '0;
  assign set = (we_i && addr_i == REG_FLAG_SET) ? wdata_i : '0;

  gpio_edge_irq_flags #(.WIDTH(WIDTH)) u_flags (
    .clk_i, .rst_ni, .evt_i(evt), .clr_i(clr), .set_i(set), .flag_o(flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pol_q <= '0;
      gie_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (we_i && addr_i == REG_ENABLE)   en_q  <= wdata_i;
      if (we_i && addr_i == REG_POLARITY) pol_q <= wdata_i;
      if (we_i && addr_i == REG_GLOBAL)   gie_q <= wdata_i[0];
      irq_q <= gie_q && ((flags & en_q) != '0);
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_FLAG_CLR, REG_FLAG_SET: rdata_o = flags;
      REG_ENABLE:                 rdata_o = en_q;
      REG_POLARITY:               rdata_o = pol_q;
      REG_GLOBAL:                 rdata_o = {{(WIDTH-1){1'b0}}, gie_q};
      default:                    rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  p_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_q |=> !irq_o);

  p_raise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_q && ((flags & en_q) != '0)) |=> irq_o);

  p_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags & en_q) == '0) |=> !irq_o);
endmodule

// File: tb/gpio_edge_irq_test.sv
`timescale 1ns/100ps
module gpio_edge_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin = 8'hA5;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gpio_edge_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #2 clk = ~clk;

  // behavioural reference
  logic [7:0] m_flag, m_en, m_pol;
  logic       m_gie, m_irq;
  logic [7:0] hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = 0; m_en = 0; m_pol = 0; m_gie = 0; m_irq = 0;
      hist.delete();
    end else begin
      logic [7:0] ev, clr, setv;
      logic       irq_n;
      int sz;
      ev = 0;
      sz = hist.size();
      if (sz >= 3)
        for (int i = 0; i < 8; i++) begin
          logic older, newer;
          older = hist[sz-3][i];
          newer = hist[sz-2][i];
          if (!m_pol[i] && !older && newer) ev[i] = 1'b1;
          if (m_pol[i] && older && !newer) ev[i] = 1'b1;
        end
      irq_n = m_gie && ((m_flag & m_en) != 0);
      clr  = (we && addr == 3'd0) ? wdata : 8'h00;
      setv = (we && addr == 3'd1) ? wdata : 8'h00;
      m_flag = (m_flag & ~clr) | setv | ev;
      if (we && addr == 3'd2) m_en = wdata;
      if (we && addr == 3'd3) m_pol = wdata;
      if (we && addr == 3'd4) m_gie = wdata[0];
      m_irq = irq_n;
      hist.push_back(pin);
      if (hist.size() > 6) void'(hist.pop_front());
    end
  end

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return m_flag;
      3'd2: return m_en;
      3'd3: return m_pol;
      3'd4: return {7'd0, m_gie};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 irq vs model", {7'd0, irq}, {7'd0, m_irq});
      chk("R12 rdata vs model", rdata, m_read(addr));
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) begin @(negedge clk); #0.5; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    cyc();
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    addr = a; #0.5;
    chk(tag, rdata, exp);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    rd(3'd0, 8'h00, "R11 flags");
    rd(3'd2, 8'h00, "R11 enable");
    rd(3'd3, 8'h00, "R11 polarity");
    rd(3'd4, 8'h00, "R11 global");
    chk("R11 irq", {7'd0, irq}, 8'h00);
    cyc(8);
    rd(3'd0, 8'h00, "R3 high-at-reset pins");

    pin = 8'hA7;
    cyc(2);
    rd(3'd0, 8'h00, "R13 not yet");
    cyc();
    rd(3'd0, 8'h02, "R1 rising sets / R13 latency");

    wr(3'd3, 8'h03);
    cyc(5);
    rd(3'd0, 8'h02, "R8 polarity write");
    wr(3'd3, 8'h01);
    cyc(4);
    rd(3'd0, 8'h02, "R8 polarity write back");

    pin = 8'h86;
    cyc(4);
    rd(3'd0, 8'h03, "R2 falling sets, wrong direction ignored");

    wr(3'd0, 8'h02);
    rd(3'd0, 8'h01, "R6 w1c");
    wr(3'd0, 8'h00);
    rd(3'd0, 8'h01, "R6 zero write");

    wr(3'd2, 8'h01);
    pin = 8'hC6;
    cyc(4);
    chk("R5 masked irq", {7'd0, irq}, 8'h00);
    rd(3'd0, 8'h41, "R5 flags set while masked");

    wr(3'd4, 8'h01);
    chk("R4 latency low", {7'd0, irq}, 8'h00);
    cyc();
    chk("R4 irq raised", {7'd0, irq}, 8'h01);

    pin = 8'hC2;
    cyc(4);
    wr(3'd2, 8'h05);
    pin = 8'hC6;
    cyc(4);
    rd(3'd0, 8'h45, "R10 second flag pending");
    wr(3'd0, 8'h01);
    cyc();
    chk("R10 irq held by pending flag", {7'd0, irq}, 8'h01);
    wr(3'd0, 8'h04);
    cyc();
    chk("R10 irq drops after clear", {7'd0, irq}, 8'h00);
    pin = 8'hC2;
    cyc(4);
    pin = 8'hC6;
    cyc(5);
    chk("R10 edge after return re-raises", {7'd0, irq}, 8'h01);

    wr(3'd0, 8'hFF);
    rd(3'd0, 8'h00, "R6 clear all");
    pin = 8'hCE;
    cyc(2);
    wr(3'd0, 8'h08);
    rd(3'd0, 8'h08, "R7 edge wins over clear");
    wr(3'd0, 8'h08);
    rd(3'd0, 8'h00, "R7 later clear");

    wr(3'd1, 8'h80);
    rd(3'd1, 8'h80, "R9 software set");
    wr(3'd2, 8'h80);
    cyc();
    chk("R9 software irq", {7'd0, irq}, 8'h01);

    wr(3'd5, 8'hFF);
    wr(3'd6, 8'hFF);
    rd(3'd5, 8'h00, "R12 addr5");
    rd(3'd6, 8'h00, "R12 addr6");
    rd(3'd7, 8'h00, "R12 addr7");
    rd(3'd2, 8'h80, "R12 enable readback");
    rd(3'd3, 8'h01, "R12 polarity readback");
    rd(3'd4, 8'h01, "R12 global readback");

    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) == 0) pin = pin ^ (8'h01 << $urandom_range(0, 7));
      if ($urandom_range(0, 4) == 0) begin
        we = 1'b1;
        addr = 3'($urandom_range(0, 7));
        wdata = 8'($urandom);
      end else begin
        we = 1'b0;
        addr = 3'($urandom_range(0, 7));
      end
      cyc();
    end
    we = 1'b0;
    cyc(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule